// File: doc/BRIEF.md
# Interrupt Mask and Pending Controller

This block holds the interrupt state of a processor: a pending-request register, an interrupt mask, a global enable flag and a fault register. The processor reaches this state through 16-bit I/O command codes, each with a data operand. The commands can load or read the mask, set or clear pending requests, enable or disable interrupts, and read the fault register and then clear it. Hardware request pulses and fault-bit set inputs update the same state alongside the command traffic. The block reports the winning interrupt as a request flag together with its encoded number.

Interrupt n sits at register bit `W-1-n`, so interrupt 0 is the most significant bit. Interrupt 0 has the highest priority, and a lower number always beats a higher one. Interrupt 0 ignores both the mask and the global enable. Interrupt 1 is the fault summary: it is held pending whenever the fault register is nonzero.

An instruction-boundary strobe marks each completed instruction. The strobe sets the moment when a deferred enable takes hold, and the moment when a software-set request may first be seen.

Top module: `irq_mask_pend_ctl`

## Requirements
- R1: Command 16'h2000 loads all W bits of the mask from `cmd_data` at the next edge. A mask bit at 1 lets its interrupt through and a 0 blocks it.
- R2: `irq_num` reports the lowest-numbered interrupt whose pending bit (register bit W-1-n) is set and whose mask bit is set while enabled. Interrupt 0 is reported even when masked or disabled. With no request, `irq_req` is 0 and `irq_num` is 0.
- R3: Command 16'h2001 zeroes the whole pending register and the whole fault register.
- R4: Command 16'h2002 raises the enable flag only once two `instr_done` strobes have been seen. A strobe in the same cycle as the command counts as the first.
- R5: Command 16'h2003 blocks every interrupt except interrupt 0, starting in its own cycle. It also cancels an enable that is still waiting for its strobes.
- R6: Command 16'h2004 clears only the pending bit whose number is `cmd_data[3:0]`. When that number is 1, it also zeroes the fault register.
- R7: Command 16'h2005 ORs `cmd_data` into the pending register. From then on, `irq_req` stays 0 until two `instr_done` strobes have been seen. A strobe in the command cycle counts as the first.
- R8: Commands 16'hA000 (mask) and 16'hA004 (pending) return the register on `rd_data`, with `rd_valid` high in the same cycle, and do not change it.
- R9: Command 16'hA00F returns the fault register on `rd_data`, then zeroes it and clears pending bit 1.
- R10: Whenever the fault register is nonzero, pending bit 1 (register bit W-2) is set at the same edge.
- R11: `hw_req` and `fault_set` bits are ORed in at every edge. When a set and a clear reach the same bit in the same cycle, the set wins.
- R12: After reset, all registers are zero and interrupts are disabled. Command codes outside the list change nothing and leave `rd_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_code | input | 16 | Command code |
| cmd_data | input | W | Command operand |
| instr_done | input | 1 | Instruction-boundary strobe |
| hw_req | input | W | Hardware request pulses, in register bit layout |
| fault_set | input | W | Fault bits to set |
| rd_valid | output | 1 | Read command this cycle; `rd_data` is valid |
| rd_data | output | W | Read result |
| irq_req | output | 1 | Interrupt request |
| irq_num | output | $clog2(W) | Number of the winning interrupt |

## Verification
Some properties hold on every cycle, and the in-line assertions check them: a reported interrupt is always pending, a disable command leaves only interrupt 0 visible in its own cycle, a nonzero fault register always has pending bit 1 set, hardware requests always survive a clear in the same cycle, and a mask write lands exactly. Other behaviour depends on a sequence of commands and strobes, so only the bench scenarios can show it: priority between several pending interrupts, the two-strobe delay after enable and after set-pending, the fault clear tied to interrupt 1, and the values returned by reads.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

   localparam int CODE_W = 16;

   localparam logic [CODE_W-1:0] CODE_MASK_WR  = 16'h2000;
   localparam logic [CODE_W-1:0] CODE_CLR_ALL  = 16'h2001;
   localparam logic [CODE_W-1:0] CODE_EN       = 16'h2002;
   localparam logic [CODE_W-1:0] CODE_DIS      = 16'h2003;
   localparam logic [CODE_W-1:0] CODE_PEND_RST = 16'h2004;
   localparam logic [CODE_W-1:0] CODE_PEND_OR  = 16'h2005;
   localparam logic [CODE_W-1:0] CODE_MASK_RD  = 16'hA000;
   localparam logic [CODE_W-1:0] CODE_PEND_RD  = 16'hA004;
   localparam logic [CODE_W-1:0] CODE_FAULT_RC = 16'hA00F;

   typedef struct packed {
      logic mask_wr;
      logic clr_all;
      logic en_cmd;
      logic dis_cmd;
      logic pend_rst;
      logic pend_or;
      logic mask_rd;
      logic pend_rd;
      logic fault_rc;
   } cmd_dec_t;

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
   import irq_ctl_pkg::*;
(
   input  logic              cmd_valid,
   input  logic [CODE_W-1:0] cmd_code,
   output cmd_dec_t          dec,
   output logic              is_read
);

   always_comb begin
      dec = '0;
      if (cmd_valid) begin
         unique case (cmd_code)
            CODE_MASK_WR:  dec.mask_wr  = 1'b1;
            CODE_CLR_ALL:  dec.clr_all  = 1'b1;
            CODE_EN:       dec.en_cmd   = 1'b1;
            CODE_DIS:      dec.dis_cmd  = 1'b1;
            CODE_PEND_RST: dec.pend_rst = 1'b1;
            CODE_PEND_OR:  dec.pend_or  = 1'b1;
            CODE_MASK_RD:  dec.mask_rd  = 1'b1;
            CODE_PEND_RD:  dec.pend_rd  = 1'b1;
            CODE_FAULT_RC: dec.fault_rc = 1'b1;
            default:       dec = '0;
         endcase
      end
   end

   assign is_read = dec.mask_rd | dec.pend_rd | dec.fault_rc;

endmodule

// File: rtl/irq_pri_enc.sv
module irq_pri_enc #(
   parameter int W  = 16,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  req_by_num,
   output logic          any,
   output logic [IW-1:0] idx
);

   if (W < 2) begin : g_bad_w
      $error("irq_pri_enc: W must be at least 2");
   end

   always_comb begin
      idx = '0;
      for (int n = W - 1; n >= 0; n--) begin
         if (req_by_num[n]) idx = IW'(n);
      end
   end

   assign any = |req_by_num;

endmodule

// File: rtl/irq_enable_seq.sv
module irq_enable_seq #(
   parameter int LAT = 2,
   parameter int CW  = $clog2(LAT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic instr_done,
   input  logic en_cmd,
   input  logic dis_cmd,
   input  logic or_cmd,
   output logic enabled,
   output logic shadow
);

   if (LAT < 2) begin : g_bad_lat
      $error("irq_enable_seq: LAT must be at least 2");
   end

   logic [CW-1:0] arm_q;
   logic [CW-1:0] shd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enabled <= 1'b0;
         arm_q   <= '0;
      end else if (dis_cmd) begin
         enabled <= 1'b0;
         arm_q   <= '0;
      end else if (en_cmd) begin
         arm_q   <= instr_done ? CW'(LAT - 1) : CW'(LAT);
      end else if (instr_done && arm_q != '0) begin
         arm_q   <= arm_q - 1'b1;
         if (arm_q == CW'(1)) enabled <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shd_q <= '0;
      end else if (or_cmd) begin
         shd_q <= instr_done ? CW'(LAT - 1) : CW'(LAT);
      end else if (instr_done && shd_q != '0) begin
         shd_q <= shd_q - 1'b1;
      end
   end

   assign shadow = (shd_q != '0);

   // R4
   en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enabled) |-> $past(instr_done));

   // R5
   dis_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_cmd |=> !enabled);

endmodule

// File: rtl/irq_mask_pend_ctl.sv
module irq_mask_pend_ctl
   import irq_ctl_pkg::*;
#(
   parameter int           W          = 16,
   parameter int           FAULT_NUM  = 1,
   parameter logic [W-1:0] NMI_NUMS   = 1,
   parameter int           ENABLE_LAT = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [CODE_W-1:0]    cmd_code,
   input  logic [W-1:0]         cmd_data,
   input  logic                 instr_done,
   input  logic [W-1:0]         hw_req,
   input  logic [W-1:0]         fault_set,
   output logic                 rd_valid,
   output logic [W-1:0]         rd_data,
   output logic                 irq_req,
   output logic [$clog2(W)-1:0] irq_num
);

   localparam int IDW       = $clog2(W);
   localparam int FAULT_BIT = W - 1 - FAULT_NUM;
   localparam logic [W-1:0] FAULT_VEC = {{(W-1){1'b0}}, 1'b1} << FAULT_BIT;
   localparam logic [W-1:0] TOP_VEC   = {1'b1, {(W-1){1'b0}}};

   if (W < 2 || (W & (W - 1)) != 0) begin : g_bad_w
      $error("irq_mask_pend_ctl: W must be a power of two, at least 2");
   end
   if (FAULT_NUM < 0 || FAULT_NUM >= W) begin : g_bad_fault
      $error("irq_mask_pend_ctl: FAULT_NUM out of range");
   end

   cmd_dec_t dec;
   logic     en_q;
   logic     shadow;

   irq_cmd_decode u_dec (
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .dec       (dec),
      .is_read   (rd_valid)
   );

   irq_enable_seq #(.LAT(ENABLE_LAT)) u_en (
      .clk        (clk),
      .rst_n      (rst_n),
      .instr_done (instr_done),
      .en_cmd     (dec.en_cmd),
      .dis_cmd    (dec.dis_cmd),
      .or_cmd     (dec.pend_or),
      .enabled    (en_q),
      .shadow     (shadow)
   );

   logic [W-1:0] mask_q, pend_q, fault_q;
   logic [W-1:0] fault_d, pend_d, pend_clr, pend_set, rst_vec;
   logic         clr_fault;

   assign rst_vec   = TOP_VEC >> cmd_data[IDW-1:0];
   assign clr_fault = dec.clr_all | dec.fault_rc |
                      (dec.pend_rst && cmd_data[IDW-1:0] == IDW'(FAULT_NUM));
   assign fault_d   = (clr_fault ? '0 : fault_q) | fault_set;

   always_comb begin
      pend_clr = '0;
      if (dec.clr_all)  pend_clr = '1;
      if (dec.pend_rst) pend_clr = pend_clr | rst_vec;
      if (dec.fault_rc) pend_clr = pend_clr | FAULT_VEC;
   end

   assign pend_set = (dec.pend_or ? cmd_data : '0) | hw_req |
                     ((|fault_d) ? FAULT_VEC : '0);
   assign pend_d   = (pend_q & ~pend_clr) | pend_set;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         pend_q  <= '0;
         fault_q <= '0;
      end else begin
         if (dec.mask_wr) mask_q <= cmd_data;
         pend_q  <= pend_d;
         fault_q <= fault_d;
      end
   end

   always_comb begin
      rd_data = '0;
      if (dec.mask_rd)  rd_data = mask_q;
      if (dec.pend_rd)  rd_data = pend_q;
      if (dec.fault_rc) rd_data = fault_q;
   end

   // Mask is enabled only while the flag is set and no disable is in flight.
   logic         en_live;
   logic [W-1:0] elig_by_num;
   logic         any_elig;
   logic [IDW-1:0] win;

   assign en_live = en_q & ~dec.dis_cmd;

   for (genvar n = 0; n < W; n++) begin : g_num
      if (NMI_NUMS[n]) begin : g_nmi
         assign elig_by_num[n] = pend_q[W-1-n];
      end else begin : g_mask
         assign elig_by_num[n] = pend_q[W-1-n] & mask_q[W-1-n] & en_live;
      end
   end

   irq_pri_enc #(.W(W), .IW(IDW)) u_pri (
      .req_by_num (elig_by_num),
      .any        (any_elig),
      .idx        (win)
   );

   assign irq_req = any_elig & ~shadow;
   assign irq_num = irq_req ? win : '0;

   // R1
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec.mask_wr |=> mask_q == $past(cmd_data));

   // R8
   mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec.mask_rd |=> $stable(mask_q));

   // R2
   irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> pend_q[(W-1) - int'(irq_num)]);

   // R5
   dis_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec.dis_cmd |-> (!irq_req || NMI_NUMS[irq_num]));

   // R10
   fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|fault_q) |-> pend_q[FAULT_BIT]);

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(hw_req)) == $past(hw_req)));

   // R9
   fault_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec.fault_rc |=> fault_q == $past(fault_set));

endmodule

// File: tb/irq_mask_pend_ctl_tb.sv
module irq_mask_pend_ctl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_code = '0;
   logic [15:0] cmd_data = '0;
   logic        instr_done = 1'b0;
   logic [15:0] hw_req = '0;
   logic [15:0] fault_set = '0;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic        irq_req;
   logic [3:0]  irq_num;

   int nchk = 0;
   int nerr = 0;

   always #5 clk = ~clk;

   irq_mask_pend_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_data(cmd_data), .instr_done(instr_done), .hw_req(hw_req),
      .fault_set(fault_set), .rd_valid(rd_valid), .rd_data(rd_data),
      .irq_req(irq_req), .irq_num(irq_num)
   );

   // {code, data, expected rd_valid, expected rd_data}
   localparam int NV = 12;
   localparam logic [48:0] VECS [0:NV-1] = '{
      {16'h2000, 16'h1234, 1'b0, 16'h0000},  // R1 mask write
      {16'hA000, 16'h0000, 1'b1, 16'h1234},  // R8 read mask
      {16'h2005, 16'h00F0, 1'b0, 16'h0000},  // R7 OR into pending
      {16'hA004, 16'h0000, 1'b1, 16'h00F0},  // R8 read pending
      {16'h2004, 16'h000B, 1'b0, 16'h0000},  // R6 clear interrupt 11
      {16'hA004, 16'h0000, 1'b1, 16'h00E0},  // R6
      {16'h2005, 16'h0003, 1'b0, 16'h0000},  // R7
      {16'hA004, 16'h0000, 1'b1, 16'h00E3},  // R7
      {16'h2006, 16'hFFFF, 1'b0, 16'h0000},  // R12 unknown code
      {16'hA000, 16'h0000, 1'b1, 16'h1234},  // R12 mask untouched
      {16'h2001, 16'h0000, 1'b0, 16'h0000},  // R3 clear all
      {16'hA004, 16'h0000, 1'b1, 16'h0000}   // R3
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [15:0] code, input logic [15:0] data,
                        input logic done, input logic [15:0] hw, input logic [15:0] fs);
      @(negedge clk);
      cmd_valid  = v;
      cmd_code   = code;
      cmd_data   = data;
      instr_done = done;
      hw_req     = hw;
      fault_set  = fs;
      #1;
   endtask

   task automatic idle(input logic done, input logic [15:0] hw, input logic [15:0] fs);
      drive(1'b0, 16'h0000, 16'h0000, done, hw, fs);
   endtask

   task automatic cmd(input logic [15:0] code, input logic [15:0] data, input logic done);
      drive(1'b1, code, data, done, 16'h0000, 16'h0000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      idle(1'b0, 16'h0, 16'h0);
      check("R12 irq_req", {31'd0, irq_req}, 32'd0);
      check("R12 irq_num", {28'd0, irq_num}, 32'd0);
      check("R12 rd_valid", {31'd0, rd_valid}, 32'd0);
      cmd(16'hA000, 16'h0, 1'b0);
      check("R12 mask", {16'd0, rd_data}, 32'd0);
      cmd(16'hA004, 16'h0, 1'b0);
      check("R12 pending", {16'd0, rd_data}, 32'd0);
      cmd(16'hA00F, 16'h0, 1'b0);
      check("R12 fault", {16'd0, rd_data}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         cmd(VECS[i][48:33], VECS[i][32:17], 1'b0);
         check("R8 vec rd_valid", {31'd0, rd_valid}, {31'd0, VECS[i][16]});
         if (VECS[i][16]) check("R8 vec rd_data", {16'd0, rd_data}, {16'd0, VECS[i][15:0]});
      end

      // R4 enable after two strobes, command-cycle strobe counted
      cmd(16'h2000, 16'hFFFF, 1'b0);
      idle(1'b0, 16'h0400, 16'h0);
      cmd(16'h2002, 16'h0, 1'b1);
      check("R4 not yet (cmd cycle)", {31'd0, irq_req}, 32'd0);
      idle(1'b1, 16'h0, 16'h0);
      check("R4 not yet (one strobe)", {31'd0, irq_req}, 32'd0);
      idle(1'b0, 16'h0, 16'h0);
      check("R4 enabled irq_req", {31'd0, irq_req}, 32'd1);
      check("R2 num 5", {28'd0, irq_num}, 32'd5);

      // R2 priority
      idle(1'b0, 16'h1000, 16'h0);
      check("R2 num still 5", {28'd0, irq_num}, 32'd5);
      idle(1'b0, 16'h0, 16'h0);
      check("R2 num 3 wins", {28'd0, irq_num}, 32'd3);

      // R1 masking interrupt 3
      cmd(16'h2000, 16'hEFFF, 1'b0);
      check("R1 mask not yet", {28'd0, irq_num}, 32'd3);
      idle(1'b0, 16'h0, 16'h0);
      check("R1 masked 3 -> 5", {28'd0, irq_num}, 32'd5);

      // R5 disable immediate
      cmd(16'h2003, 16'h0, 1'b0);
      check("R5 same cycle", {31'd0, irq_req}, 32'd0);
      idle(1'b0, 16'h0, 16'h0);
      check("R5 after", {31'd0, irq_req}, 32'd0);

      // R2 interrupt 0 ignores disable; R6 clears it
      idle(1'b0, 16'h8000, 16'h0);
      idle(1'b0, 16'h0, 16'h0);
      check("R2 nmi req", {31'd0, irq_req}, 32'd1);
      check("R2 nmi num", {28'd0, irq_num}, 32'd0);
      cmd(16'h2004, 16'h0000, 1'b0);
      idle(1'b0, 16'h0, 16'h0);
      check("R6 nmi cleared", {31'd0, irq_req}, 32'd0);

      // R4 with later strobes
      cmd(16'h2002, 16'h0, 1'b0);
      idle(1'b1, 16'h0, 16'h0);
      check("R4 first strobe", {31'd0, irq_req}, 32'd0);
      idle(1'b1, 16'h0, 16'h0);
      check("R4 second strobe", {31'd0, irq_req}, 32'd0);
      idle(1'b0, 16'h0, 16'h0);
      check("R4 enabled num 5", {27'd0, irq_req, irq_num}, 32'h15);

      // R3 clear all, R7 shadow
      cmd(16'h2001, 16'h0, 1'b0);
      idle(1'b0, 16'h0, 16'h0);
      check("R3 no request", {31'd0, irq_req}, 32'd0);
      cmd(16'h2005, 16'h0200, 1'b0);
      idle(1'b0, 16'h0, 16'h0);
      check("R7 shadow 0", {31'd0, irq_req}, 32'd0);
      idle(1'b1, 16'h0, 16'h0);
      check("R7 shadow 1", {31'd0, irq_req}, 32'd0);
      idle(1'b1, 16'h0, 16'h0);
      check("R7 shadow 2", {31'd0, irq_req}, 32'd0);
      idle(1'b0, 16'h0, 16'h0);
      check("R7 visible num 6", {27'd0, irq_req, irq_num}, 32'h16);

      // R10 fault sets pending 1, R9 read and clear
      idle(1'b0, 16'h0, 16'h0008);
      cmd(16'hA004, 16'h0, 1'b0);
      check("R10 pending bit 1", {16'd0, rd_data}, 32'h4200);
      check("R10 irq num 1", {28'd0, irq_num}, 32'd1);
      cmd(16'hA00F, 16'h0, 1'b0);
      check("R9 fault read", {16'd0, rd_data}, 32'h0008);
      cmd(16'hA004, 16'h0, 1'b0);
      check("R9 pending 1 cleared", {16'd0, rd_data}, 32'h0200);
      cmd(16'hA00F, 16'h0, 1'b0);
      check("R9 fault zero", {16'd0, rd_data}, 32'h0000);

      // R6 reset of interrupt 1 wipes fault
      idle(1'b0, 16'h0, 16'h0020);
      cmd(16'h2004, 16'h0001, 1'b0);
      cmd(16'hA00F, 16'h0, 1'b0);
      check("R6 fault wiped", {16'd0, rd_data}, 32'h0000);
      cmd(16'hA004, 16'h0, 1'b0);
      check("R6 pending 1 gone", {16'd0, rd_data}, 32'h0200);

      // R11 set beats clear
      drive(1'b1, 16'h2004, 16'h0006, 1'b0, 16'h0200, 16'h0);
      cmd(16'hA004, 16'h0, 1'b0);
      check("R11 hw beats reset", {16'd0, rd_data}, 32'h0200);
      drive(1'b1, 16'h2001, 16'h0, 1'b0, 16'h0, 16'h0001);
      cmd(16'hA004, 16'h0, 1'b0);
      check("R11 fault beats clear-all pend", {16'd0, rd_data}, 32'h4000);
      cmd(16'hA00F, 16'h0, 1'b0);
      check("R11 fault kept", {16'd0, rd_data}, 32'h0001);
      cmd(16'hA004, 16'h0, 1'b0);
      check("R9 pending after read-clear", {16'd0, rd_data}, 32'h0000);

      idle(1'b0, 16'h0, 16'h0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule